// File: doc/BRIEF.md
# ADC Conversion Control Sequencer

This block is the digital controller of a 12-bit successive-approximation converter. It holds a small configuration register that picks one of several start sources, sets the sampling window length, and chooses between a single conversion and a repeating run. When a start event arrives, it opens the sample switch for a programmed number of timer-clock cycles. It then resolves the result one bit per cycle, most significant bit first, by driving trial codes to the DAC and reading back a comparator bit.

The finished 12-bit value is kept in a result register. It is presented on a 16-bit read port either left- or right-justified. The justification is applied on the read path, so flipping it reformats the stored value at once without changing it. The analog comparator and DAC sit outside this block.

Top module: `adc_seq`

## Requirements
- R1: The start source is chosen by configuration bits 4:3. Code 0 starts on a rising edge of `sw_start_i`. Code 1 starts on a high cycle of `tmr_uf_i`. Code 3 starts on a rising edge of `ext_trig_i`, which first passes through two synchronising flops. The unselected sources have no effect.
- R2: Trigger-select code 2 never starts a conversion, whatever the inputs do.
- R3: `sample_o` stays high for exactly (configuration bits 2:0) + 4 consecutive cycles per conversion, so between 4 and 11 cycles.
- R4: After sampling, 12 conversion cycles follow. In each one `dac_o` carries the bits kept so far plus one trial bit, starting at bit 11. The trial bit is kept when `cmp_i` is high. The stored result equals the input value the comparator represents.
- R5: `done_o` is a one-cycle pulse in the cycle after the last conversion cycle, and `result_o` holds the new value in that same cycle.
- R6: With configuration bit 6 at 1, `result_o` is {result, 4'b0}. With bit 6 at 0, it is {4'b0, result}.
- R7: A change of the justification bit while idle changes `result_o` in the cycle after the write, and the stored 12-bit value is unchanged.
- R8: A configuration write made while `busy_o` is high is ignored.
- R9: With configuration bit 5 at 1, a new sampling phase begins right after each result while `sw_start_i` is high, and `busy_o` stays high between conversions. When `sw_start_i` is low at the end of a conversion, the block stops after that result and `busy_o` falls in the `done_o` cycle. With bit 5 at 0, the block stops after one result.
- R10: Start events that arrive while `busy_o` is high are ignored and are not held for later.
- R11: After reset, `busy_o`, `sample_o`, `done_o`, `dac_o` and `result_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timer clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 7 | Configuration: [2:0] sampling, [4:3] trigger select, [5] continuous, [6] left-justify |
| sw_start_i | input | 1 | Software start bit (level) |
| tmr_uf_i | input | 1 | Timer underflow pulse |
| ext_trig_i | input | 1 | Asynchronous external trigger pin |
| cmp_i | input | 1 | Comparator: input at least the DAC code |
| sample_o | output | 1 | Sample switch enable |
| dac_o | output | 12 | DAC trial code |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | Result written pulse |
| result_o | output | 16 | Justified result |

## Verification
Random single conversions draw the analog level, the sampling field, the justification bit and the start source together. A wrong sampling count, a misread trial bit or a swapped layout each shows up in a different check. Input levels of 0 and full scale test whether the lowest and highest bits resolve correctly at the ends of the range. Directed sequences cover four further cases. The first is code 2 with every source toggling. The second is a start pulse during a conversion, which separates ignoring from queuing. The third is a configuration write during busy, followed by a justification flip while idle, which separates read-path formatting from store-time formatting. The fourth is a continuous run with the level changed between results and the start bit dropped mid-run, which shows that conversion ends only after the result in progress.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int SMP_W = 3;
  localparam int SEL_W = 2;

  localparam logic [SEL_W-1:0] SEL_SW  = 2'd0;
  localparam logic [SEL_W-1:0] SEL_TMR = 2'd1;
  localparam logic [SEL_W-1:0] SEL_RSV = 2'd2;
  localparam logic [SEL_W-1:0] SEL_EXT = 2'd3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SAMPLE,
    ST_CONV
  } state_e;

  typedef struct packed {
    logic             left;
    logic             cont;
    logic [SEL_W-1:0] sel;
    logic [SMP_W-1:0] smp;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);
endpackage

// File: rtl/adc_seq_trig.sv
module adc_seq_trig
  import adc_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             sw_start_i,
  input  logic             tmr_uf_i,
  input  logic             ext_trig_i,
  output logic             fire_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   ext_prev_q;
  logic                   sw_prev_q;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[s] <= 1'b0;
      else if (s == 0) sync_q[s] <= ext_trig_i;
      else sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ext_prev_q <= 1'b0;
      sw_prev_q  <= 1'b0;
    end else begin
      ext_prev_q <= sync_q[SYNC_STAGES-1];
      sw_prev_q  <= sw_start_i;
    end
  end

  always_comb begin
    unique case (sel_i)
      SEL_SW:  fire_o = sw_start_i & ~sw_prev_q;
      SEL_TMR: fire_o = tmr_uf_i;
      SEL_EXT: fire_o = sync_q[SYNC_STAGES-1] & ~ext_prev_q;
      default: fire_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/adc_seq_sar.sv
module adc_seq_sar #(
  parameter int RES_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cmp_i,
  output logic [RES_W-1:0] dac_o,
  output logic [RES_W-1:0] next_code_o,
  output logic             last_o
);
  localparam int IDX_W = $clog2(RES_W);

  logic [RES_W-1:0] code_q;
  logic [IDX_W-1:0] bit_q;
  logic             run_q;
  logic [RES_W-1:0] trial;

  assign trial       = code_q | (RES_W'(1) << bit_q);
  assign dac_o       = run_q ? trial : '0;
  assign next_code_o = cmp_i ? trial : code_q;
  assign last_o      = run_q && (bit_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      bit_q  <= '0;
      run_q  <= 1'b0;
    end else if (start_i) begin
      code_q <= '0;
      bit_q  <= IDX_W'(RES_W-1);
      run_q  <= 1'b1;
    end else if (run_q) begin
      code_q <= next_code_o;
      if (bit_q == '0) run_q <= 1'b0;
      else bit_q <= bit_q - 1'b1;
    end
  end
endmodule

// File: rtl/adc_seq_fmt.sv
module adc_seq_fmt #(
  parameter int RES_W = 12,
  parameter int OUT_W = 16
) (
  input  logic             left_i,
  input  logic [RES_W-1:0] value_i,
  output logic [OUT_W-1:0] data_o
);
  localparam int PAD_W = OUT_W - RES_W;

  assign data_o = left_i ? {value_i, {PAD_W{1'b0}}} : {{PAD_W{1'b0}}, value_i};
endmodule

// File: rtl/adc_seq.sv
module adc_seq
  import adc_seq_pkg::*;
#(
  parameter int RES_W       = 12,
  parameter int OUT_W       = 16,
  parameter int SMP_BASE    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic             sw_start_i,
  input  logic             tmr_uf_i,
  input  logic             ext_trig_i,
  input  logic             cmp_i,
  output logic             sample_o,
  output logic [RES_W-1:0] dac_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [OUT_W-1:0] result_o
);
  localparam int CNT_W = $clog2((1 << SMP_W) + SMP_BASE);

  cfg_t             cfg_q;
  state_e           state_q;
  logic [CNT_W-1:0] smp_cnt_q;
  logic [RES_W-1:0] result_q;
  logic             done_q;
  logic             fire;
  logic             sar_start;
  logic             sar_last;
  logic [RES_W-1:0] sar_next;
  logic [CNT_W-1:0] smp_load;

  assign busy_o    = (state_q != ST_IDLE);
  assign sample_o  = (state_q == ST_SAMPLE);
  assign done_o    = done_q;
  assign smp_load  = CNT_W'(cfg_q.smp) + CNT_W'(SMP_BASE - 1);
  assign sar_start = (state_q == ST_SAMPLE) && (smp_cnt_q == '0);

  // config is frozen while a conversion runs
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else if (cfg_we_i && !busy_o) cfg_q <= cfg_t'(cfg_wdata_i);
  end

  adc_seq_trig #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (cfg_q.sel),
    .sw_start_i (sw_start_i),
    .tmr_uf_i   (tmr_uf_i),
    .ext_trig_i (ext_trig_i),
    .fire_o     (fire)
  );

  adc_seq_sar #(.RES_W(RES_W)) u_sar (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (sar_start),
    .cmp_i       (cmp_i),
    .dac_o       (dac_o),
    .next_code_o (sar_next),
    .last_o      (sar_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      smp_cnt_q <= '0;
      result_q  <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (fire) begin
            state_q   <= ST_SAMPLE;
            smp_cnt_q <= smp_load;
          end
        end
        ST_SAMPLE: begin
          if (smp_cnt_q == '0) state_q <= ST_CONV;
          else smp_cnt_q <= smp_cnt_q - 1'b1;
        end
        ST_CONV: begin
          if (sar_last) begin
            result_q <= sar_next;
            done_q   <= 1'b1;
            if (cfg_q.cont && sw_start_i) begin
              state_q   <= ST_SAMPLE;
              smp_cnt_q <= smp_load;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  adc_seq_fmt #(.RES_W(RES_W), .OUT_W(OUT_W)) u_fmt (
    .left_i  (cfg_q.left),
    .value_i (result_q),
    .data_o  (result_o)
  );
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk
  import adc_seq_pkg::*;
#(
  parameter int OUT_W    = 16,
  parameter int SMP_BASE = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_we_i,
  input cfg_t             cfg_q,
  input logic             sample_o,
  input logic             busy_o,
  input logic             done_o,
  input logic [OUT_W-1:0] result_o
);
  localparam int RUN_W = SMP_W + 3;

  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= '0;
    else if (sample_o) run_q <= run_q + 1'b1;
    else run_q <= '0;
  end

  // R3
  sample_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sample_o && run_q != '0) |-> (run_q == RUN_W'(cfg_q.smp) + RUN_W'(SMP_BASE)));

  // R5
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R2
  reserved_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && cfg_q.sel == SEL_RSV) |=> !sample_o);

  // R8
  cfg_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cfg_we_i) |=> $stable(cfg_q));

  // R6
  right_pad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_q.left |-> (result_o[OUT_W-1 -: 4] == 4'b0));

  // R11
  sample_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> busy_o);
endmodule

bind adc_seq adc_seq_chk #(.OUT_W(OUT_W), .SMP_BASE(SMP_BASE)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cfg_we_i (cfg_we_i),
  .cfg_q    (cfg_q),
  .sample_o (sample_o),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .result_o (result_o)
);

// File: tb/adc_seq_test.sv
`timescale 1ns/1ps
module adc_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [6:0]  cfg_wdata = '0;
  logic        sw_start = 1'b0;
  logic        tmr_uf = 1'b0;
  logic        ext_trig = 1'b0;
  logic        cmp;
  logic        sample;
  logic [11:0] dac;
  logic        busy;
  logic        done;
  logic [15:0] result;
  logic [11:0] vin = '0;

  int checks = 0;
  int failures = 0;
  int samp_run = 0, last_samp = 0;
  int conv_run = 0, last_conv = 0;
  int done_cnt = 0;
  bit prev_done = 0;

  always #2 clk = ~clk;

  assign cmp = (vin >= dac);

  adc_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .sw_start_i(sw_start), .tmr_uf_i(tmr_uf), .ext_trig_i(ext_trig), .cmp_i(cmp),
    .sample_o(sample), .dac_o(dac), .busy_o(busy), .done_o(done), .result_o(result)
  );

  function automatic logic [15:0] fmt(input logic [11:0] v, input bit left);
    return left ? {v, 4'b0} : {4'b0, v};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  // monitor, sampled at negedge
  always @(negedge clk) begin
    if (sample) samp_run++;
    else if (samp_run != 0) begin last_samp = samp_run; samp_run = 0; end
    if (busy && !sample) conv_run++;
    if (done) begin
      last_conv = conv_run; conv_run = 0; done_cnt++;
      chk(!prev_done, "R5 done width", 2, 1);
    end
    prev_done = done;
  end

  task automatic write_cfg(input int smp, input int sel, input bit cont, input bit left);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = {left, cont, 2'(sel), 3'(smp)};
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic trigger(input int sel);
    @(negedge clk);
    case (sel)
      0: begin sw_start = 1'b1; @(negedge clk); sw_start = 1'b0; end
      1: begin tmr_uf = 1'b1; @(negedge clk); tmr_uf = 1'b0; end
      default: begin ext_trig = 1'b1; repeat (3) @(negedge clk); ext_trig = 1'b0; end
    endcase
  endtask

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (done) begin ok = 1; break; end
    end
    #1;
    chk(ok, "R4 done seen", 0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=0x0 exp=0x1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bit ok;
    int d0;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11
    chk(!busy && !sample && !done, "R11 reset flags", {busy, sample, done}, 0);
    chk(result == 0 && dac == 0, "R11 reset data", result, 0);

    // R1 R3 R4 R5 R6 random single conversions
    for (int it = 0; it < 30; it++) begin
      int smp, sel;
      bit left;
      smp  = $urandom % 8;
      sel  = $urandom % 3;
      if (sel == 2) sel = 3;
      left = $urandom % 2;
      vin  = (it == 0) ? 12'h000 : (it == 1) ? 12'hfff : 12'($urandom);
      write_cfg(smp, sel, 1'b0, left);
      trigger(sel);
      wait_done(ok);
      chk(result == fmt(vin, left), "R1/R4/R6 result", result, fmt(vin, left));
      chk(last_samp == smp + 4, "R3 sample length", last_samp, smp + 4);
      chk(last_conv == 12, "R4 conversion cycles", last_conv, 12);
      chk(!busy, "R9 one-time stops", busy, 0);
    end

    // R2 reserved select
    write_cfg(0, 2, 1'b0, 1'b0);
    d0 = done_cnt;
    ok = 1;
    fork
      trigger(0);
      trigger(1);
      trigger(3);
    join
    repeat (10) begin @(negedge clk); if (busy) ok = 0; end
    chk(ok && done_cnt == d0, "R2 reserved no start", busy, 0);

    // R10 triggers during busy ignored
    write_cfg(2, 1, 1'b0, 1'b0);
    vin = 12'h5a5;
    trigger(1);
    while (!busy) @(negedge clk);
    repeat (9) @(negedge clk);
    tmr_uf = 1'b1; @(negedge clk); tmr_uf = 1'b0;
    d0 = done_cnt;
    wait_done(ok);
    ok = 1;
    repeat (8) begin @(negedge clk); if (busy) ok = 0; end
    chk(ok && done_cnt == d0 + 1, "R10 busy trigger dropped", done_cnt - d0, 1);

    // R8 config write while busy ignored
    write_cfg(1, 0, 1'b0, 1'b0);
    vin = 12'h3c7;
    trigger(0);
    while (!busy) @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = {1'b1, 1'b0, 2'd1, 3'd7};
    @(negedge clk); cfg_we = 1'b0;
    wait_done(ok);
    chk(result == fmt(12'h3c7, 0), "R8 write while busy", result, fmt(12'h3c7, 0));
    chk(last_samp == 5, "R8 sampling kept", last_samp, 5);

    // R7 read-path justification
    write_cfg(1, 0, 1'b0, 1'b1);
    #1;
    chk(result == fmt(12'h3c7, 1), "R7 flip to left", result, fmt(12'h3c7, 1));
    write_cfg(1, 0, 1'b0, 1'b0);
    #1;
    chk(result == fmt(12'h3c7, 0), "R7 flip back", result, fmt(12'h3c7, 0));

    // R9 continuous mode
    write_cfg(1, 0, 1'b1, 1'b0);
    vin = 12'h123;
    @(negedge clk); sw_start = 1'b1;
    wait_done(ok);
    chk(result == fmt(12'h123, 0), "R9 first result", result, 12'h123);
    chk(busy, "R9 busy held", busy, 1);
    vin = 12'habc;
    wait_done(ok);
    chk(result == fmt(12'habc, 0), "R9 second result", result, 12'habc);
    chk(busy && last_samp == 5, "R9 restart sampled", last_samp, 5);
    vin = 12'h801;
    repeat (3) @(negedge clk);
    sw_start = 1'b0;
    wait_done(ok);
    chk(result == fmt(12'h801, 0), "R9 final result", result, 12'h801);
    chk(!busy, "R9 stop after current", busy, 0);
    d0 = done_cnt;
    repeat (30) @(negedge clk);
    chk(done_cnt == d0 && !busy, "R9 stays stopped", done_cnt - d0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule